// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits beside an 8-bit timer/counter. The counter itself lives elsewhere and supplies its current count, a per-cycle timer enable (tick), and indications that it is at the top or bottom of its count. The channel compares that count against an active compare value. A match sets a sticky flag and updates a single output bit. Depending on a two-bit action code, the output bit is held, toggled, cleared or set.

The channel has four waveform modes. In the two PWM modes the compare value is double-buffered: bus writes land in a holding register, and the active value is refreshed only at a counting boundary, so the pulse widths stay consistent. In the two non-PWM modes, bus writes reach the active value directly. Software can also force a match in non-PWM modes, which changes only the output. A write to the counter arms a one-shot blocker so that software can preload the count without an unwanted match.

Top module: `ocmp_channel`

## Requirements
- R1: After reset, the flag is 0, the output bit is 0, and both the active and buffered compare values are 0.
- R2: A real match happens when tick is 1, the count equals the active compare value, and no block is pending. The flag reads 1 from the following cycle.
- R3: On a real or forced match, the output bit changes in the following cycle according to comMode: 2'b00 keeps it, 2'b01 toggles it, 2'b10 drives 0 and 2'b11 drives 1. Without a tick or force strobe, the output bit holds.
- R4: In non-PWM modes (wgMode 2'b00 normal, 2'b10 clear-on-compare), a compare write becomes the active value in the next cycle.
- R5: In PWM modes, a compare write only fills the buffer. The buffer is copied to the active value on a tick with atTop in phase-correct mode (wgMode 2'b01), or on a tick with atBottom in fast mode (wgMode 2'b11). At any other time in a PWM mode, the active value does not change.
- R6: A force strobe in a non-PWM mode applies the comMode action to the output bit in the next cycle and never sets the flag.
- R7: A force strobe in a PWM mode has no effect on the output bit.
- R8: A counter write suppresses matches from the next cycle up to and including the first tick after it. This holds however many untimed cycles pass before that tick.
- R9: The flag stays set until flagClr is 1. When a match and flagClr fall in the same cycle, the flag stays set.
- R10: The output bit keeps its value when wgMode changes.
- R11: A change of comMode applies to the very next match, with no buffering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable for this cycle |
| cntVal | input | W | Current counter value |
| atTop | input | 1 | Counter is at the top of its sequence |
| atBottom | input | 1 | Counter is at the bottom of its sequence |
| wgMode | input | 2 | Waveform mode: 00 normal, 01 phase-correct PWM, 10 clear-on-compare, 11 fast PWM |
| comMode | input | 2 | Output action on match: 00 keep, 01 toggle, 10 clear, 11 set |
| ocrWr | input | 1 | Bus write strobe for the compare value |
| ocrWrData | input | W | Compare value being written |
| cntWr | input | 1 | Bus write strobe for the counter |
| focWr | input | 1 | Force-match strobe |
| flagClr | input | 1 | Clear the match flag |
| matchFlag | output | 1 | Sticky compare-match flag |
| ocOut | output | 1 | Output waveform bit |

## Verification
On every cycle, the assertions check the following:
- The flag stays set until it is cleared, and flagClr clears it when no tick is present.
- A force strobe or a pending counter-write block never raises the flag.
- The output bit holds when there is neither a tick nor a force strobe, and PWM modes ignore the force strobe.
- The active compare value only moves at the permitted points.

The bench scenarios cover the rest: the exact cycle of a match across full counter sweeps for several compare values, the order of buffer loads at top versus bottom in each PWM mode, the blocker surviving idle cycles, and the full table of action codes from both output starting levels.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic [1:0] {
    WG_NORMAL   = 2'b00,
    WG_PWM_PC   = 2'b01,
    WG_CTC      = 2'b10,
    WG_PWM_FAST = 2'b11
  } wgMode_e;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } outAct_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic writeBuf;
    logic writeDirect;
    logic loadActive;
    logic applyOut;
  } ctrlStb_t;

endpackage

// File: rtl/ocmp_ctrl.sv
module ocmp_ctrl
  import ocmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       atTop,
  input  logic       atBottom,
  input  logic [1:0] wgMode,
  input  logic       ocrWr,
  input  logic       cntWr,
  input  logic       focWr,
  input  logic       flagClr,
  input  logic       cmpEq,
  output ctrlStb_t   stb,
  output logic       matchFlag
);

  wgMode_e modeNow;
  logic    isPwm;
  logic    loadPoint;
  logic    blockQ;
  logic    realMatch;
  logic    forceHit;

  assign modeNow = wgMode_e'(wgMode);
  assign isPwm   = (modeNow == WG_PWM_PC) || (modeNow == WG_PWM_FAST);

  // phase-correct refreshes at the top, fast PWM at the bottom
  always_comb begin
    unique case (modeNow)
      WG_PWM_PC:   loadPoint = atTop;
      WG_PWM_FAST: loadPoint = atBottom;
      default:     loadPoint = 1'b0;
    endcase
  end

  // one-shot blocker armed by a counter write, released by the next tick
  always_ff @(posedge clk) begin
    if (!rstN)      blockQ <= 1'b0;
    else if (cntWr) blockQ <= 1'b1;
    else if (tick)  blockQ <= 1'b0;
  end

  assign realMatch = tick && cmpEq && !blockQ;
  assign forceHit  = focWr && !isPwm;

  always_comb begin
    stb.writeBuf    = ocrWr;
    stb.writeDirect = ocrWr && !isPwm;
    stb.loadActive  = isPwm && tick && loadPoint;
    stb.applyOut    = realMatch || forceHit;
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rstN)          matchFlag <= 1'b0;
    else if (realMatch) matchFlag <= 1'b1;
    else if (flagClr)   matchFlag <= 1'b0;
  end

endmodule

// File: rtl/ocmp_dpath.sv
module ocmp_dpath
  import ocmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStb_t     stb,
  input  logic [W-1:0] cntVal,
  input  logic [W-1:0] ocrWrData,
  input  logic [1:0]   comMode,
  output logic         cmpEq,
  output logic [W-1:0] ocrActive,
  output logic         ocOut
);

  logic [W-1:0] ocrBuf;
  outAct_e      actNow;

  always_ff @(posedge clk) begin
    if (!rstN)             ocrBuf <= '0;
    else if (stb.writeBuf) ocrBuf <= ocrWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                ocrActive <= '0;
    else if (stb.writeDirect) ocrActive <= ocrWrData;
    else if (stb.loadActive)  ocrActive <= ocrBuf;
  end

  assign cmpEq  = (cntVal == ocrActive);
  assign actNow = outAct_e'(comMode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ocOut <= 1'b0;
    end else if (stb.applyOut) begin
      unique case (actNow)
        ACT_TOGGLE: ocOut <= ~ocOut;
        ACT_CLEAR:  ocOut <= 1'b0;
        ACT_SET:    ocOut <= 1'b1;
        default:    ocOut <= ocOut;
      endcase
    end
  end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic [W-1:0] cntVal,
  input  logic         atTop,
  input  logic         atBottom,
  input  logic [1:0]   wgMode,
  input  logic [1:0]   comMode,
  input  logic         ocrWr,
  input  logic [W-1:0] ocrWrData,
  input  logic         cntWr,
  input  logic         focWr,
  input  logic         flagClr,
  output logic         matchFlag,
  output logic         ocOut
);

  ctrlStb_t     stb;
  logic         cmpEq;
  logic [W-1:0] ocrActive;

  ocmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .atTop(atTop), .atBottom(atBottom),
    .wgMode(wgMode), .ocrWr(ocrWr), .cntWr(cntWr), .focWr(focWr),
    .flagClr(flagClr), .cmpEq(cmpEq), .stb(stb), .matchFlag(matchFlag)
  );

  ocmp_dpath #(.W(W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cntVal(cntVal), .ocrWrData(ocrWrData),
    .comMode(comMode), .cmpEq(cmpEq), .ocrActive(ocrActive), .ocOut(ocOut)
  );

endmodule

// File: rtl/ocmp_checker.sv
module ocmp_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         tick,
  input logic         atTop,
  input logic         atBottom,
  input logic [1:0]   wgMode,
  input logic         ocrWr,
  input logic [W-1:0] ocrWrData,
  input logic         cntWr,
  input logic         focWr,
  input logic         flagClr,
  input logic         matchFlag,
  input logic         ocOut,
  input logic [W-1:0] ocrActive
);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !flagClr) |=> matchFlag);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !tick) |=> !matchFlag);

  p_force_no_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (focWr && !tick && !matchFlag) |=> !matchFlag);

  p_block_no_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cntWr) && !matchFlag) |=> !matchFlag);

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !focWr) |=> $stable(ocOut));

  p_pwm_force_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wgMode[0] && !tick) |=> $stable(ocOut));

  p_pwm_active_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wgMode[0] && !(tick && (atTop || atBottom))) |=> $stable(ocrActive));

  p_direct_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wgMode[0] && ocrWr) |=> (ocrActive == $past(ocrWrData)));

endmodule

bind ocmp_channel ocmp_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .atTop(atTop), .atBottom(atBottom),
  .wgMode(wgMode), .ocrWr(ocrWr), .ocrWrData(ocrWrData), .cntWr(cntWr),
  .focWr(focWr), .flagClr(flagClr), .matchFlag(matchFlag), .ocOut(ocOut),
  .ocrActive(ocrActive)
);

// File: tb/tb_ocmp_channel.sv
module tb_ocmp_channel;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         tick;
  logic [W-1:0] cntVal;
  logic         atTop;
  logic         atBottom;
  logic [1:0]   wgMode;
  logic [1:0]   comMode;
  logic         ocrWr;
  logic [W-1:0] ocrWrData;
  logic         cntWr;
  logic         focWr;
  logic         flagClr;
  logic         matchFlag;
  logic         ocOut;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ocmp_channel #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .cntVal(cntVal), .atTop(atTop),
    .atBottom(atBottom), .wgMode(wgMode), .comMode(comMode), .ocrWr(ocrWr),
    .ocrWrData(ocrWrData), .cntWr(cntWr), .focWr(focWr), .flagClr(flagClr),
    .matchFlag(matchFlag), .ocOut(ocOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic writeOcr(input int v);
    ocrWr = 1'b1; ocrWrData = W'(v);
    cyc();
    ocrWr = 1'b0;
  endtask

  task automatic tickAt(input int c, input bit top, input bit bot);
    tick = 1'b1; cntVal = W'(c); atTop = top; atBottom = bot;
    cyc();
    tick = 1'b0; atTop = 1'b0; atBottom = 1'b0;
  endtask

  task automatic forceHit();
    focWr = 1'b1;
    cyc();
    focWr = 1'b0;
  endtask

  task automatic clearFlag();
    flagClr = 1'b1;
    cyc();
    flagClr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tick = 1'b0; cntVal = '0; atTop = 1'b0; atBottom = 1'b0;
    wgMode = 2'b00; comMode = 2'b00; ocrWr = 1'b0; ocrWrData = '0;
    cntWr = 1'b0; focWr = 1'b0; flagClr = 1'b0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1: reset state
    chk("R1 flag", matchFlag, 0);
    chk("R1 out", ocOut, 0);
    tickAt(0, 0, 0);
    chk("R1 active compare is zero", matchFlag, 1);
    clearFlag();

    // R2: full counter sweeps, flag set only where count equals compare
    foreach (sweepVals[i]) begin
      writeOcr(sweepVals[i]);
      clearFlag();
      for (int c = 0; c < 256; c++) begin
        flagClr = 1'b1;
        tickAt(c, 0, 0);
        chk("R2 sweep match", matchFlag, (c == sweepVals[i]) ? 1 : 0);
      end
      flagClr = 1'b0;
      clearFlag();
    end

    // R3/R6: every action code from both starting levels, forced
    for (int st = 0; st < 2; st++) begin
      for (int cm = 0; cm < 4; cm++) begin
        wgMode = 2'b00;
        comMode = (st == 1) ? 2'b11 : 2'b10;
        forceHit();
        comMode = 2'(cm);
        forceHit();
        chk("R3 force action", ocOut,
            (cm == 0) ? st : (cm == 1) ? 1 - st : (cm == 2) ? 0 : 1);
        chk("R6 force leaves flag clear", matchFlag, 0);
      end
    end

    // R6: forced toggle in clear-on-compare mode
    wgMode = 2'b10; comMode = 2'b10; forceHit();
    comMode = 2'b01; forceHit();
    chk("R6 ctc forced toggle", ocOut, 1);
    chk("R6 ctc forced toggle flag", matchFlag, 0);

    // R7: force ignored in both PWM modes
    wgMode = 2'b01; comMode = 2'b01; forceHit();
    chk("R7 pc force ignored", ocOut, 1);
    wgMode = 2'b11; comMode = 2'b10; forceHit();
    chk("R7 fast force ignored", ocOut, 1);

    // R10: mode changes keep the output bit
    wgMode = 2'b00; cyc();
    chk("R10 to normal", ocOut, 1);
    wgMode = 2'b10; cyc();
    chk("R10 to ctc", ocOut, 1);

    // R4: direct write in clear-on-compare mode
    comMode = 2'b00;
    writeOcr(40);
    tickAt(40, 0, 0);
    chk("R4 immediate write", matchFlag, 1);
    clearFlag();

    // R5: phase-correct loads only at top
    wgMode = 2'b00; writeOcr(10);
    wgMode = 2'b01; writeOcr(20);
    tickAt(20, 0, 0);
    chk("R5 pc buffered not yet active", matchFlag, 0);
    tickAt(10, 0, 0);
    chk("R5 pc old value still active", matchFlag, 1);
    clearFlag();
    tickAt(0, 0, 1);
    tickAt(20, 0, 0);
    chk("R5 pc no load at bottom", matchFlag, 0);
    tickAt(255, 1, 0);
    tickAt(20, 0, 0);
    chk("R5 pc load at top", matchFlag, 1);
    clearFlag();

    // R5: fast PWM loads only at bottom
    wgMode = 2'b11; writeOcr(30);
    tickAt(255, 1, 0);
    tickAt(30, 0, 0);
    chk("R5 fast no load at top", matchFlag, 0);
    tickAt(0, 0, 1);
    chk("R5 fast bottom tick no match", matchFlag, 0);
    tickAt(30, 0, 0);
    chk("R5 fast load at bottom", matchFlag, 1);
    clearFlag();

    // R8: counter write equal to compare gives no flag, even after idle cycles
    wgMode = 2'b00; writeOcr(50);
    cntWr = 1'b1; cntVal = 8'd50; cyc(); cntWr = 1'b0;
    repeat (3) cyc();
    tickAt(50, 0, 0);
    chk("R8 blocked tick", matchFlag, 0);
    tickAt(50, 0, 0);
    chk("R8 released", matchFlag, 1);

    // R9: sticky flag and set-beats-clear
    repeat (3) cyc();
    chk("R9 sticky", matchFlag, 1);
    clearFlag();
    chk("R9 cleared", matchFlag, 0);
    flagClr = 1'b1;
    tickAt(50, 0, 0);
    flagClr = 1'b0;
    chk("R9 set wins over clear", matchFlag, 1);
    clearFlag();

    // R11: action code change applies at once
    comMode = 2'b10; forceHit();
    comMode = 2'b11; tickAt(50, 0, 0);
    chk("R11 set", ocOut, 1);
    comMode = 2'b10; tickAt(50, 0, 0);
    chk("R11 clear", ocOut, 0);
    comMode = 2'b01; tickAt(50, 0, 0);
    chk("R11 toggle", ocOut, 1);
    comMode = 2'b00; tickAt(50, 0, 0);
    chk("R3 keep on real match", ocOut, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  int sweepVals[4] = '{0, 7, 128, 255};

endmodule